// File: doc/BRIEF.md
# Staged Trace Clock Divider

This block derives a trace clock from a fast input clock by dividing it by 2 or by 4. The divide ratio is chosen through a 2-bit code written over a simple register write port. A written code only lands in a staging register. It reaches the running divider after software writes a separate load strobe, and even then the change waits for the next rising edge of the divided clock. Every output period is therefore whole and has a 50% duty cycle.

Codes 0 and 3 are not supported and are never accepted into the divider. A load strobe that carries one of them is dropped, and the divider keeps the ratio it has. Software reads back the staged code. A separate status output shows which code the divider is running.

Top module: `trace_clk_divider`

## Requirements
- R1: After reset the staged code and the active code are both 2, `trace_clk` is low, and the output divides by 4.
- R2: Active code 1 divides the input clock by 2 (one cycle high, one cycle low). Active code 2 divides it by 4 (two cycles high, two cycles low).
- R3: Codes 0 and 3 never become the active code. A load strobe with one of these codes leaves the active code and any pending legal request unchanged.
- R4: A write with `wr_load` = 0 updates only the staged code. `active_ratio` and the `trace_clk` waveform stay as they were.
- R5: A legal code written with `wr_load` = 1 becomes active at the first rising edge of `trace_clk` after the write. `active_ratio` changes only in the cycle where `trace_clk` rises.
- R6: For either active code, the high phase and the low phase of `trace_clk` have equal length. There is no shortened pulse across a ratio change.
- R7: `staged_ratio` shows the code of the most recent write, legal or not, from the cycle after that write.
- R8: A second legal load strobe that arrives before a pending change has been applied replaces the pending code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_ratio | input | 2 | Ratio code written to the staging register |
| wr_load | input | 1 | Write-only strobe bit. 1 requests transfer of the written code to the divider |
| staged_ratio | output | 2 | Readback of the staged code |
| active_ratio | output | 2 | Code the divider is currently running |
| trace_clk | output | 1 | Divided trace clock |

## Verification
The embedded assertions check four things on every cycle. The active code stays legal. It moves only on a rising edge of the divided clock. Divide-by-2 toggles on every cycle. Plain writes and illegal strobes leave the active code alone. Whole-waveform properties need the bench's scenarios, because they depend on a history of writes. These are the exact cycle at which a staged change lands, the equal phase lengths across a switch, and the replacement of a pending code by a later strobe. The bench compares a behavioural model against every output on every clock.

// File: rtl/trace_clk_divider.sv
module trace_clk_divider #(
  parameter logic [1:0] RESET_CODE = 2'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_ratio,
  input  logic       wr_load,
  output logic [1:0] staged_ratio,
  output logic [1:0] active_ratio,
  output logic       trace_clk
);

  logic [1:0] staged_q, active_q, pend_code;
  logic       pend_vld, phase_cnt, clk_q;

  wire legal_wr  = (wr_ratio == 2'd1) || (wr_ratio == 2'd2);
  wire strobe    = wr_en && wr_load;
  wire half_len1 = (active_q == 2'd1);
  wire end_half  = half_len1 || phase_cnt;
  wire apply     = end_half && !clk_q && pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) staged_q <= RESET_CODE;
    else if (wr_en) staged_q <= wr_ratio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_cnt <= 1'b0;
      clk_q     <= 1'b0;
    end else if (end_half) begin
      phase_cnt <= 1'b0;
      clk_q     <= ~clk_q;
    end else begin
      phase_cnt <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= RESET_CODE;
      pend_vld  <= 1'b0;
      pend_code <= RESET_CODE;
    end else begin
      if (apply) begin
        active_q <= pend_code;
        pend_vld <= 1'b0;
      end
      if (strobe && legal_wr) begin
        pend_vld  <= 1'b1;
        pend_code <= wr_ratio;
      end
    end
  end

  assign staged_ratio = staged_q;
  assign active_ratio = active_q;
  assign trace_clk    = clk_q;

  assert_active_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_ratio == 2'd1) || (active_ratio == 2'd2));

  assert_switch_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_ratio) |-> $rose(trace_clk));

  assert_div2_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_ratio == 2'd1) |=> (trace_clk != $past(trace_clk)));

  assert_plain_write_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_load && !pend_vld) |=> $stable(active_ratio));

  assert_illegal_strobe_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !legal_wr && !pend_vld) |=> ($stable(active_ratio) && !pend_vld));

  assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (staged_ratio == $past(wr_ratio)));

endmodule

// File: tb/trace_clk_divider_bench.sv
module trace_clk_divider_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_load = 1'b0;
  logic [1:0] wr_ratio = 2'd0;
  logic [1:0] staged_ratio, active_ratio;
  logic trace_clk;

  integer checks = 0, errors = 0;
  integer m_div = 0, m_cnt = 0, m_active = 2, m_staged = 2, m_pend = -1;
  integer prev_active = 2, prev_div = 0;
  bit done = 0;

  trace_clk_divider u_trace_clk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ratio(wr_ratio), .wr_load(wr_load),
    .staged_ratio(staged_ratio), .active_ratio(active_ratio), .trace_clk(trace_clk));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_active = 2; m_staged = 2; m_pend = -1;
    end else begin
      m_cnt++;
      if (m_cnt == ((m_active == 1) ? 1 : 2)) begin
        m_cnt = 0;
        if (m_div == 0 && m_pend >= 0) begin
          m_active = m_pend;
          m_pend = -1;
        end
        m_div = 1 - m_div;
      end
      if (wr_en) begin
        m_staged = wr_ratio;
        if (wr_load && (wr_ratio == 1 || wr_ratio == 2)) m_pend = wr_ratio;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(trace_clk == m_div[0], "R6 trace_clk", trace_clk, m_div);
      check(active_ratio == m_active[1:0], "R5 active_ratio", active_ratio, m_active);
      check(staged_ratio == m_staged[1:0], "R7 staged_ratio", staged_ratio, m_staged);
      if (active_ratio != prev_active)
        check(trace_clk && prev_div == 0, "R5 switch_on_rise", trace_clk, 1);
      prev_active = active_ratio;
      prev_div = trace_clk;
    end
  end

  task automatic write(input logic [1:0] code, input logic load);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_ratio = code; wr_load = load;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_load = 1'b0;
  endtask

  task automatic idle(input integer n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input integer exp_half, input string tag);
    integer hi, lo;
    hi = 0; lo = 0;
    @(negedge clk);
    while (trace_clk) @(negedge clk);
    while (!trace_clk) @(negedge clk);
    while (trace_clk) begin hi++; @(negedge clk); end
    while (!trace_clk) begin lo++; @(negedge clk); end
    check(hi == exp_half, {tag, " high phase"}, hi, exp_half);
    check(lo == exp_half, {tag, " low phase"}, lo, exp_half);
  endtask

  initial begin
    idle(2);
    check(active_ratio == 2'd2 && staged_ratio == 2'd2 && !trace_clk, "R1 reset state", active_ratio, 2);
    #1 rst_n = 1'b1;
    measure(2, "R1 div4 after reset");
    write(2'd1, 1'b0);
    check(active_ratio == 2'd2, "R4 plain write keeps active", active_ratio, 2);
    measure(2, "R4 waveform unchanged");
    check(staged_ratio == 2'd1, "R7 staged readback", staged_ratio, 1);
    write(2'd1, 1'b1);
    idle(6);
    check(active_ratio == 2'd1, "R2 code1 active", active_ratio, 1);
    measure(1, "R2 div2");
    write(2'd0, 1'b1);
    idle(4);
    check(active_ratio == 2'd1, "R3 code0 rejected", active_ratio, 1);
    check(staged_ratio == 2'd0, "R7 illegal staged readback", staged_ratio, 0);
    write(2'd3, 1'b1);
    idle(4);
    check(active_ratio == 2'd1, "R3 code3 rejected", active_ratio, 1);
    write(2'd2, 1'b1);
    idle(4);
    check(active_ratio == 2'd2, "R2 code2 active", active_ratio, 2);
    measure(2, "R6 div4 after switch");
    @(posedge trace_clk); @(negedge clk); #1;
    wr_en = 1'b1; wr_ratio = 2'd1; wr_load = 1'b1;
    @(negedge clk); #1;
    wr_ratio = 2'd2;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_load = 1'b0;
    idle(8);
    check(active_ratio == 2'd2, "R8 later strobe replaces pending", active_ratio, 2);
    write(2'd1, 1'b1);
    write(2'd3, 1'b1);
    idle(6);
    check(active_ratio == 2'd1, "R3 illegal keeps pending", active_ratio, 1);
    for (int k = 0; k < 6; k++) begin
      write((k % 2) ? 2'd2 : 2'd1, 1'b1);
      idle(k + 1);
    end
    idle(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule